// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block buffers the stores of an out-of-order core between dispatch and the moment the data cache has accepted them. Stores take a slot at the tail in program order. The slot index is handed back to the core, and the core later uses it to write the store's address, byte count and data word, and then to mark the store committed. Committed stores drain strictly in order through a writeback pointer to a cache write port. A slot is released only after the cache acknowledges the write, not when the store commits.

Loads probe the queue through a lookup port. A load presents the slot index that the store tail held when the load was dispatched, together with its own address and byte count. The queue walks the older stores from youngest to oldest and answers one cycle later. The answer is one of three outcomes:
- forward, with the load's bytes extracted from the store data;
- stall and replay, when a store covers only part of the load;
- miss, when the load must read memory.

A squash input carrying a sequence number cuts away every store younger than that number.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_idx` is 0 and `full`, `wb_valid` and `rsp_valid` are 0.
- R2: An allocation takes the slot shown on `alloc_idx`, and `alloc_idx` then advances by one modulo SLOTS. `full` is high while SLOTS-1 slots are occupied (one slot is always left empty). An allocation while `full` is high is ignored.
- R3: A store is written to the cache only once it is committed, is not yet written, and `cache_blocked` is low in that cycle. Stores are written strictly in allocation order. `wb_addr`, `wb_data` and `wb_size` appear with `wb_valid` one cycle after the cycle in which the write was decided.
- R4: A slot is released one cycle after the cache acknowledges its write on `wb_ack` (acks arrive in write order). Commit and write alone never release a slot, so `full` stays high until an ack arrives.
- R5: Every lookup cycle (`ld_valid` high) produces exactly one response cycle on the next cycle. `rsp_code` is 2'b00 for miss, 2'b01 for forward and 2'b10 for stall.
- R6: A forward occurs when the load's byte range [addr, addr+size) lies entirely within a store's range. `rsp_data` then equals the store data shifted right by 8 × (load address − store address), keeping only the low `ld_size` bytes and zeroing the rest.
- R7: The scan covers only stores older than the load's index, back to the oldest occupied slot. The youngest store that decides the outcome wins.
- R8: A store whose range overlaps the load only partly gives a stall. The exception is a store whose write has already been acknowledged: the scan skips it and continues with older stores.
- R9: A store whose size is still zero (not yet filled) never matches and is skipped.
- R10: A squash removes every store whose sequence number is greater than `squash_seq`, and the tail moves back to follow the last kept store. A squash takes priority over an allocation in the same cycle, and that allocation is dropped. Squashed slots that are later reallocated carry no stale address.
- R11: Slot indices wrap. A load whose index is 0 scans back through the highest-numbered slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a slot for a new store |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_idx | output | IDX_W | Slot the next allocation takes (current tail) |
| full | output | 1 | SLOTS-1 slots occupied |
| fill_valid | input | 1 | Write address, size and data into a slot |
| fill_idx | input | IDX_W | Slot being filled |
| fill_addr | input | ADDR_W | Store byte address |
| fill_size | input | SZ_W | Store size in bytes (1..DATA_W/8) |
| fill_data | input | DATA_W | Store data, byte 0 in the low bits |
| commit_valid | input | 1 | Mark a slot committed and writable |
| commit_idx | input | IDX_W | Slot being committed |
| squash_valid | input | 1 | Squash stores younger than `squash_seq` |
| squash_seq | input | SEQ_W | Youngest sequence number kept |
| ld_valid | input | 1 | Lookup request |
| ld_sq_idx | input | IDX_W | Store tail recorded when the load dispatched |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SZ_W | Load size in bytes |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_code | output | 2 | 00 miss, 01 forward, 10 stall |
| rsp_data | output | DATA_W | Forwarded bytes (zero unless forward) |
| cache_blocked | input | 1 | Cache cannot take a write this cycle |
| wb_valid | output | 1 | Store write to cache |
| wb_addr | output | ADDR_W | Write address |
| wb_data | output | DATA_W | Write data |
| wb_size | output | SZ_W | Write size in bytes |
| wb_ack | input | 1 | Cache finished the oldest outstanding write |

## Verification
The lookup and the write acknowledge can fall in the same cycle and act on the same store. The bench provokes this by raising `wb_ack` for the oldest store together with a load that overlaps that store only partly. The load is judged against the state before the ack, so it must stall. The same load repeated one cycle later must see the store as completed, skip it and miss, and `full` must drop once the slot is released on that edge.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    FWD_MISS  = 2'b00,
    FWD_HIT   = 2'b01,
    FWD_STALL = 2'b10
  } fwd_code_e;
endpackage

// File: rtl/sq_storage.sv
module sq_storage #(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         alloc_we,
  input  logic [$clog2(SLOTS)-1:0]     alloc_idx,
  input  logic [SEQ_W-1:0]             alloc_seq,
  input  logic                         fill_we,
  input  logic [$clog2(SLOTS)-1:0]     fill_idx,
  input  logic [ADDR_W-1:0]            fill_addr,
  input  logic [$clog2(DATA_W/8):0]    fill_size,
  input  logic [DATA_W-1:0]            fill_data,
  input  logic                         commit_we,
  input  logic [$clog2(SLOTS)-1:0]     commit_idx,
  input  logic                         ack_we,
  input  logic [$clog2(SLOTS)-1:0]     ack_idx,
  input  logic [SLOTS-1:0]             clear_mask,
  output logic [SLOTS-1:0][ADDR_W-1:0] st_addr,
  output logic [SLOTS-1:0][DATA_W-1:0] st_data,
  output logic [SLOTS-1:0][$clog2(DATA_W/8):0] st_size,
  output logic [SLOTS-1:0][SEQ_W-1:0]  st_seq,
  output logic [SLOTS-1:0]             can_wb,
  output logic [SLOTS-1:0]             committed,
  output logic [SLOTS-1:0]             completed
);
  localparam int IDX_W = $clog2(SLOTS);

  // Control state: reset, cleared per slot on allocation or squash.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_size   <= '0;
      can_wb    <= '0;
      committed <= '0;
      completed <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if ((alloc_we && alloc_idx == IDX_W'(i)) || clear_mask[i]) begin
          st_size[i]   <= '0;
          can_wb[i]    <= 1'b0;
          committed[i] <= 1'b0;
          completed[i] <= 1'b0;
        end else begin
          if (fill_we && fill_idx == IDX_W'(i))     st_size[i]   <= fill_size;
          if (commit_we && commit_idx == IDX_W'(i)) begin
            committed[i] <= 1'b1;
            can_wb[i]    <= 1'b1;
          end
          if (ack_we && ack_idx == IDX_W'(i))       completed[i] <= 1'b1;
        end
      end
    end
  end

  // Payload: single write port per field, no reset.
  always_ff @(posedge clk) begin
    if (fill_we) begin
      st_addr[fill_idx] <= fill_addr;
      st_data[fill_idx] <= fill_data;
    end
    if (alloc_we) st_seq[alloc_idx] <= alloc_seq;
  end
endmodule

// File: rtl/sq_fwd_scan.sv
module sq_fwd_scan
  import sq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic [$clog2(SLOTS)-1:0]     ld_idx,
  input  logic [ADDR_W-1:0]            ld_addr,
  input  logic [$clog2(DATA_W/8):0]    ld_size,
  input  logic [$clog2(SLOTS)-1:0]     head,
  input  logic [SLOTS-1:0][ADDR_W-1:0] st_addr,
  input  logic [SLOTS-1:0][DATA_W-1:0] st_data,
  input  logic [SLOTS-1:0][$clog2(DATA_W/8):0] st_size,
  input  logic [SLOTS-1:0]             completed,
  output fwd_code_e                    code,
  output logic [DATA_W-1:0]            data
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  logic [IDX_W-1:0]  depth;
  logic [IDX_W-1:0]  pos;
  logic [ADDR_W:0]   ld_lo, ld_hi, st_lo, st_hi;
  logic              done, contain, overlap;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] mask;

  always_comb begin
    for (int b = 0; b < BYTES; b++)
      mask[b*8 +: 8] = (($clog2(BYTES)+1)'(b) < ld_size) ? 8'hFF : 8'h00;
  end

  always_comb begin
    depth   = ld_idx - head;
    ld_lo   = {1'b0, ld_addr};
    ld_hi   = {1'b0, ld_addr} + (ADDR_W+1)'(ld_size);
    done    = 1'b0;
    code    = FWD_MISS;
    data    = '0;
    pos     = '0;
    st_lo   = '0;
    st_hi   = '0;
    contain = 1'b0;
    overlap = 1'b0;
    off     = '0;
    // Youngest older store first; stop after the oldest occupied slot.
    for (int k = 1; k < SLOTS; k++) begin
      pos     = ld_idx - IDX_W'(k);
      st_lo   = {1'b0, st_addr[pos]};
      st_hi   = {1'b0, st_addr[pos]} + (ADDR_W+1)'(st_size[pos]);
      contain = (ld_lo >= st_lo) && (ld_hi <= st_hi);
      overlap = (ld_lo < st_hi) && (ld_hi > st_lo);
      if (!done && IDX_W'(k) <= depth && st_size[pos] != '0) begin
        if (contain) begin
          done = 1'b1;
          code = FWD_HIT;
          off  = OFF_W'(ld_addr - st_addr[pos]);
          data = (st_data[pos] >> {off, 3'b000}) & mask;
        end else if (overlap && !completed[pos]) begin
          done = 1'b1;
          code = FWD_STALL;
        end
      end
    end
  end
endmodule

// File: rtl/sq_drain.sv
module sq_drain #(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [$clog2(SLOTS)-1:0]     tail,
  input  logic [SLOTS-1:0]             can_wb,
  input  logic [SLOTS-1:0]             committed,
  input  logic [SLOTS-1:0]             completed,
  input  logic [SLOTS-1:0][ADDR_W-1:0] st_addr,
  input  logic [SLOTS-1:0][DATA_W-1:0] st_data,
  input  logic [SLOTS-1:0][$clog2(DATA_W/8):0] st_size,
  input  logic                         cache_blocked,
  output logic [$clog2(SLOTS)-1:0]     wbptr,
  output logic                         wb_valid,
  output logic [ADDR_W-1:0]            wb_addr,
  output logic [DATA_W-1:0]            wb_data,
  output logic [$clog2(DATA_W/8):0]    wb_size
);
  logic fire;

  assign fire = (wbptr != tail) && can_wb[wbptr] && !completed[wbptr] && !cache_blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbptr    <= '0;
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
      wb_size  <= '0;
    end else begin
      wb_valid <= fire;
      if (fire) begin
        wbptr   <= wbptr + 1'b1;
        wb_addr <= st_addr[wbptr];
        wb_data <= st_data[wbptr];
        wb_size <= st_size[wbptr];
      end
    end
  end

  // R3: a write only leaves in a cycle after the cache was open
  assert_wb_unblocked_R3: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(!cache_blocked));
  // R3: the store picked for writing was committed by the core
  assert_wb_committed_R3: assert property (@(posedge clk) disable iff (rst)
    fire |-> committed[wbptr]);
endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue
  import sq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      alloc_valid,
  input  logic [SEQ_W-1:0]          alloc_seq,
  output logic [$clog2(SLOTS)-1:0]  alloc_idx,
  output logic                      full,
  input  logic                      fill_valid,
  input  logic [$clog2(SLOTS)-1:0]  fill_idx,
  input  logic [ADDR_W-1:0]         fill_addr,
  input  logic [$clog2(DATA_W/8):0] fill_size,
  input  logic [DATA_W-1:0]         fill_data,
  input  logic                      commit_valid,
  input  logic [$clog2(SLOTS)-1:0]  commit_idx,
  input  logic                      squash_valid,
  input  logic [SEQ_W-1:0]          squash_seq,
  input  logic                      ld_valid,
  input  logic [$clog2(SLOTS)-1:0]  ld_sq_idx,
  input  logic [ADDR_W-1:0]         ld_addr,
  input  logic [$clog2(DATA_W/8):0] ld_size,
  output logic                      rsp_valid,
  output logic [1:0]                rsp_code,
  output logic [DATA_W-1:0]         rsp_data,
  input  logic                      cache_blocked,
  output logic                      wb_valid,
  output logic [ADDR_W-1:0]         wb_addr,
  output logic [DATA_W-1:0]         wb_data,
  output logic [$clog2(DATA_W/8):0] wb_size,
  input  logic                      wb_ack
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int SZ_W  = $clog2(DATA_W/8) + 1;

  logic [IDX_W-1:0] head, tail, ackp, wbptr, count, kept;
  logic [SLOTS-1:0] clear_mask, can_wb, committed, completed;
  logic [SLOTS-1:0][ADDR_W-1:0] st_addr;
  logic [SLOTS-1:0][DATA_W-1:0] st_data;
  logic [SLOTS-1:0][SZ_W-1:0]   st_size;
  logic [SLOTS-1:0][SEQ_W-1:0]  st_seq;
  logic             alloc_go, free_go;
  fwd_code_e        scan_code;
  logic [DATA_W-1:0] scan_data;

  assign count     = tail - head;
  assign full      = (count == IDX_W'(SLOTS - 1));
  assign alloc_idx = tail;
  assign alloc_go  = alloc_valid && !full && !squash_valid;
  assign free_go   = (head != tail) && completed[head];

  // Squash: keep the older stores in program order, drop the rest.
  always_comb begin
    kept = '0;
    for (int i = 0; i < SLOTS; i++) begin
      clear_mask[i] = 1'b0;
      if ((IDX_W'(i) - head) < count) begin
        if (st_seq[i] <= squash_seq) kept = kept + 1'b1;
        else                         clear_mask[i] = squash_valid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      ackp <= '0;
    end else begin
      if (squash_valid)  tail <= head + kept;
      else if (alloc_go) tail <= tail + 1'b1;
      if (free_go)       head <= head + 1'b1;
      if (wb_ack)        ackp <= ackp + 1'b1;
    end
  end

  sq_storage #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_store (
    .clk(clk), .rst(rst),
    .alloc_we(alloc_go), .alloc_idx(tail), .alloc_seq(alloc_seq),
    .fill_we(fill_valid), .fill_idx(fill_idx), .fill_addr(fill_addr),
    .fill_size(fill_size), .fill_data(fill_data),
    .commit_we(commit_valid), .commit_idx(commit_idx),
    .ack_we(wb_ack), .ack_idx(ackp), .clear_mask(clear_mask),
    .st_addr(st_addr), .st_data(st_data), .st_size(st_size), .st_seq(st_seq),
    .can_wb(can_wb), .committed(committed), .completed(completed)
  );

  sq_fwd_scan #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_scan (
    .ld_idx(ld_sq_idx), .ld_addr(ld_addr), .ld_size(ld_size), .head(head),
    .st_addr(st_addr), .st_data(st_data), .st_size(st_size),
    .completed(completed), .code(scan_code), .data(scan_data)
  );

  sq_drain #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drain (
    .clk(clk), .rst(rst), .tail(tail), .can_wb(can_wb), .committed(committed),
    .completed(completed), .st_addr(st_addr), .st_data(st_data), .st_size(st_size),
    .cache_blocked(cache_blocked), .wbptr(wbptr), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .wb_data(wb_data), .wb_size(wb_size)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= FWD_MISS;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= ld_valid;
      rsp_code  <= ld_valid ? scan_code : FWD_MISS;
      rsp_data  <= ld_valid ? scan_data : '0;
    end
  end

  // R2: a request while full leaves the tail where it was
  assert_full_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (full && alloc_valid && !squash_valid) |=> $stable(alloc_idx));
  // R4: the oldest slot stays until its write is acknowledged
  assert_free_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (head != tail && !completed[head]) |=> $stable(head));
  // R4: an ack must match a write already sent
  assert_ack_pending_R4: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> (ackp != wbptr));
  // R5: one response per lookup, on the following cycle
  assert_rsp_next_R5: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> rsp_valid);
  // R5: only the three defined outcome codes appear
  assert_rsp_code_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_code != 2'b11));
endmodule

// File: tb/test_store_fwd_queue.sv
module test_store_fwd_queue;
  localparam int SLOTS = 8, ADDR_W = 16, DATA_W = 32, SEQ_W = 8;
  localparam int IDX_W = 3, SZ_W = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_valid = 0, fill_valid = 0, commit_valid = 0, squash_valid = 0;
  logic ld_valid = 0, cache_blocked = 0, wb_ack = 0;
  logic [SEQ_W-1:0] alloc_seq = '0, squash_seq = '0;
  logic [IDX_W-1:0] fill_idx = '0, commit_idx = '0, ld_sq_idx = '0, alloc_idx;
  logic [ADDR_W-1:0] fill_addr = '0, ld_addr = '0, wb_addr;
  logic [SZ_W-1:0] fill_size = '0, ld_size = '0, wb_size;
  logic [DATA_W-1:0] fill_data = '0, rsp_data, wb_data;
  logic full, rsp_valid, wb_valid;
  logic [1:0] rsp_code;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0]  q_code[$];
  logic [31:0] q_data[$];
  string       q_req[$];
  logic [15:0] w_addr[$];
  logic [31:0] w_data[$];
  logic [2:0]  w_size[$];

  always #5 clk = ~clk;

  store_fwd_queue #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) i_store_fwd_queue (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_idx(alloc_idx), .full(full), .fill_valid(fill_valid), .fill_idx(fill_idx),
    .fill_addr(fill_addr), .fill_size(fill_size), .fill_data(fill_data),
    .commit_valid(commit_valid), .commit_idx(commit_idx),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .ld_valid(ld_valid), .ld_sq_idx(ld_sq_idx), .ld_addr(ld_addr), .ld_size(ld_size),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
    .cache_blocked(cache_blocked), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_size(wb_size), .wb_ack(wb_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        if (q_code.size() == 0) chk(0, "R5 unexpected response", {30'd0, rsp_code}, 32'hFFFF_FFFF);
        else begin
          logic [1:0] c; logic [31:0] d; string r;
          c = q_code.pop_front(); d = q_data.pop_front(); r = q_req.pop_front();
          chk(rsp_code == c, r, {30'd0, rsp_code}, {30'd0, c});
          if (c == 2'b01) chk(rsp_data == d, r, rsp_data, d);
        end
      end
      if (wb_valid) begin
        if (w_addr.size() == 0) chk(0, "R3 unexpected write", {16'd0, wb_addr}, 32'hFFFF_FFFF);
        else begin
          logic [15:0] a; logic [31:0] d; logic [2:0] s;
          a = w_addr.pop_front(); d = w_data.pop_front(); s = w_size.pop_front();
          chk(wb_addr == a, "R3 write address", {16'd0, wb_addr}, {16'd0, a});
          chk(wb_data == d, "R3 write data", wb_data, d);
          chk(wb_size == s, "R3 write size", {29'd0, wb_size}, {29'd0, s});
        end
      end
    end
  end

  task automatic do_alloc(input logic [7:0] s);
    alloc_valid = 1; alloc_seq = s; @(negedge clk); alloc_valid = 0;
  endtask

  task automatic do_fill(input logic [2:0] i, input logic [15:0] a, input logic [2:0] s, input logic [31:0] d);
    fill_valid = 1; fill_idx = i; fill_addr = a; fill_size = s; fill_data = d;
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic do_commit(input logic [2:0] i);
    commit_valid = 1; commit_idx = i; @(negedge clk); commit_valid = 0;
  endtask

  task automatic expect_rsp(input logic [1:0] c, input logic [31:0] d, input string r);
    q_code.push_back(c); q_data.push_back(d); q_req.push_back(r);
  endtask

  task automatic do_lookup(input logic [2:0] i, input logic [15:0] a, input logic [2:0] s,
                           input logic [1:0] c, input logic [31:0] d, input string r);
    expect_rsp(c, d, r);
    ld_valid = 1; ld_sq_idx = i; ld_addr = a; ld_size = s;
    @(negedge clk); ld_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(alloc_idx == 0, "R1 alloc_idx", {29'd0, alloc_idx}, 0);
    chk(full == 0, "R1 full", {31'd0, full}, 0);
    chk(wb_valid == 0 && rsp_valid == 0, "R1 strobes", {30'd0, wb_valid, rsp_valid}, 0);

    // R2 allocation in order
    do_alloc(10); do_alloc(11); do_alloc(12);
    chk(alloc_idx == 3, "R2 alloc_idx after three", {29'd0, alloc_idx}, 3);
    do_fill(0, 16'h0100, 4, 32'hDDCCBBAA);
    do_fill(1, 16'h0104, 2, 32'h00002211);

    // R6 and R9: slot 2 unfilled, slot 0 contains the load
    do_lookup(3, 16'h0102, 2, 2'b01, 32'h0000DDCC, "R6 forward upper half");
    do_lookup(3, 16'h0105, 1, 2'b01, 32'h00000022, "R6 forward byte");
    do_lookup(3, 16'h0103, 2, 2'b10, 0, "R8 partial overlap stall");
    do_lookup(1, 16'h0104, 2, 2'b00, 0, "R7 younger store not seen, miss");
    do_fill(2, 16'h0100, 1, 32'h00000077);
    do_lookup(3, 16'h0100, 1, 2'b01, 32'h00000077, "R7 youngest wins");
    do_lookup(3, 16'h0200, 4, 2'b00, 0, "R5 miss code");

    // R3 writeback gated by cache_blocked, then in order
    cache_blocked = 1;
    do_commit(0); do_commit(1);
    repeat (3) @(negedge clk);
    chk(wb_valid == 0, "R3 no write while blocked", {31'd0, wb_valid}, 0);
    w_addr.push_back(16'h0100); w_data.push_back(32'hDDCCBBAA); w_size.push_back(4);
    w_addr.push_back(16'h0104); w_data.push_back(32'h00002211); w_size.push_back(2);
    cache_blocked = 0;
    repeat (3) @(negedge clk);

    // R2 full and R4 no release before ack
    do_alloc(13); do_alloc(14); do_alloc(15); do_alloc(16);
    chk(full == 1, "R4 full held after writes without ack", {31'd0, full}, 1);
    chk(alloc_idx == 7, "R2 alloc_idx at full", {29'd0, alloc_idx}, 7);
    do_alloc(99);
    chk(alloc_idx == 7, "R2 alloc ignored while full", {29'd0, alloc_idx}, 7);

    // R8 same-cycle ack and lookup on store 0
    expect_rsp(2'b10, 0, "R8 stall on store acked same cycle");
    wb_ack = 1; ld_valid = 1; ld_sq_idx = 1; ld_addr = 16'h00FE; ld_size = 4;
    @(negedge clk); wb_ack = 0; ld_valid = 0;
    do_lookup(1, 16'h00FE, 4, 2'b00, 0, "R8 completed store skipped");
    chk(full == 0, "R4 slot released after ack", {31'd0, full}, 0);
    wb_ack = 1; @(negedge clk); wb_ack = 0;
    @(negedge clk);

    // R10 squash with competing allocation
    do_fill(6, 16'h0300, 4, 32'h12345678);
    squash_valid = 1; squash_seq = 14; alloc_valid = 1; alloc_seq = 50;
    @(negedge clk); squash_valid = 0; alloc_valid = 0;
    chk(alloc_idx == 5, "R10 tail after squash", {29'd0, alloc_idx}, 5);
    do_alloc(20); do_alloc(21);
    do_lookup(7, 16'h0300, 4, 2'b00, 0, "R10 squashed store gone");

    // R11 wrap
    do_alloc(22); do_alloc(23);
    chk(alloc_idx == 1, "R11 alloc_idx wrapped", {29'd0, alloc_idx}, 1);
    chk(full == 1, "R2 full across wrap", {31'd0, full}, 1);
    do_fill(7, 16'h0400, 4, 32'h44332211);
    do_lookup(0, 16'h0401, 2, 2'b01, 32'h00003322, "R11 scan wraps to top slot");

    repeat (4) @(negedge clk);
    chk(q_code.size() == 0, "R5 all responses seen", q_code.size(), 0);
    chk(w_addr.size() == 0, "R3 all writes seen", w_addr.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule